// File: doc/BRIEF.md
# Serial Configuration and Readout Port

This block is the host-facing serial port of a decimating converter. A host frames each transfer with an active-low chip select. A read/write level and a register-select level, both set before the frame opens, choose one of three frame types: a configuration write, a conversion-result read or a status read. The serial clock idles high. Read data is shifted out most significant bit first on a data-out pin. That pin has a separate output enable, which is active only while a read is selected. Write data is shifted in most significant bit first.

An 8-bit configuration register holds a 5-bit modulator control field and a 3-bit decimation-rate field. In hardware mode the register follows the parallel control and rate pins. In software mode it keeps the value of the last complete serial write. Reset always reloads it from the pins. The control field drives the modulator control outputs directly: three bits select gain or standby and two bits select the input multiplexer.

A data-ready flag marks a new conversion result and is cleared by a completed result read. Each new result is captured in a holding register, and each read frame copies its data into a separate shift register. A result that arrives in the middle of a read therefore cannot disturb the bits being sent. All serial pins are resynchronised to the system clock, so the system clock must run at least four times faster than the serial clock.

Top module: `cfg_serial_port`

## Requirements
- R1: While chip select is high, data-out enable is low, and serial clock or data-in activity changes neither the configuration nor the data-ready flag.
- R2: With chip select low, data-out enable is high when read/write is high and low when read/write is low. It follows these pins combinationally.
- R3: A read frame with register select high returns the 24-bit held result, most significant bit first. The first bit is on data out before the first falling serial-clock edge, and each later bit appears after a rising edge. It is valid at the next falling edge.
- R4: A read frame with register select low returns the 8-bit status input, most significant bit first. The status input is sampled when the frame opens.
- R5: In software mode, a write frame of exactly 8 falling-edge samples, most significant bit first, is committed when chip select rises. Written bits [7:3] appear on control outputs [4:0], and bits [2:0] appear on the rate outputs.
- R6: A write frame with any other count of falling edges (7 or 9, for example) leaves the configuration unchanged.
- R7: In hardware mode the configuration equals the parallel pins one clock later, and serial writes have no effect. In software mode, changes on the pins have no effect.
- R8: Reset loads the configuration from the parallel pins and clears data ready.
- R9: Data ready rises one clock after a result-valid pulse. It clears when chip select ends a result read with at least 24 falling edges. A shorter result read, or a status read, leaves it high.
- R10: A result that arrives during a read does not alter the bits of that read. Data ready stays high after that read ends, and the next result read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| csn_i | input | 1 | Active-low chip select framing each transfer |
| rdwr_i | input | 1 | High selects read, low selects write |
| rsel_i | input | 1 | High selects result, low selects status on a read |
| sclk_i | input | 1 | Serial clock, idles high |
| din_i | input | 1 | Serial write data |
| dout_o | output | 1 | Serial read data |
| dout_oe_o | output | 1 | Output enable for the tri-state data-out driver |
| drdy_o | output | 1 | Data-ready flag |
| hwmode_i | input | 1 | High: pins drive the configuration; low: serial writes do |
| ctl_pins_i | input | 5 | Parallel gain/standby and mux pins |
| rate_pins_i | input | 3 | Parallel decimation-rate pins |
| result_i | input | 24 | New conversion result |
| result_vld_i | input | 1 | One-clock pulse marking a new result |
| status_i | input | 8 | Status word returned by status reads |
| ctl_o | output | 5 | Modulator control outputs (gain [2:0], mux [4:3]) |
| rate_o | output | 3 | Decimation-rate setting |

## Verification
The hardest case to reach is a new result arriving partway through a result read. The old bits must keep streaming out, and the completed read must not clear data ready, because the flag now refers to a result the host has not yet seen. The stimulus pulses result-valid in the middle of a 24-bit read. The scoreboard compares every bit against the earlier value, and the flag is checked after the frame closes. A follow-up read must then return the new value. Short and over-long write frames, and a write attempted in hardware mode, reach the discard paths.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   typedef enum logic [1:0] {
      FR_IDLE    = 2'd0,
      FR_WRITE   = 2'd1,
      FR_RD_RES  = 2'd2,
      FR_RD_STAT = 2'd3
   } frame_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
   parameter int           N      = 1,
   parameter int           STAGES = 2,
   parameter logic [N-1:0] IDLE   = '0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sp_sync_edge: STAGES must be at least 2");
   end
   if (N < 1) begin : g_bad_n
      $error("sp_sync_edge: N must be positive");
   end

   logic [N-1:0] stg_q [STAGES];
   logic [N-1:0] prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= IDLE;
         prev_q <= IDLE;
      end else begin
         stg_q[0] <= async_i;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign lvl_o  = stg_q[STAGES-1];
   assign rise_o = lvl_o & ~prev_q;
   assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/sp_cfg_reg.sv
module sp_cfg_reg #(
   parameter int CTL_W  = 5,
   parameter int RATE_W = 3,
   localparam int CFG_W = CTL_W + RATE_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              hw_i,
   input  logic [CTL_W-1:0]  ctl_pins_i,
   input  logic [RATE_W-1:0] rate_pins_i,
   input  logic              commit_i,
   input  logic [CFG_W-1:0]  wdata_i,
   output logic [CTL_W-1:0]  ctl_o,
   output logic [RATE_W-1:0] rate_o
);

   logic [CFG_W-1:0] cfg_q;
   logic [CFG_W-1:0] pins_cfg;

   assign pins_cfg = {ctl_pins_i, rate_pins_i};

   always_ff @(posedge clk_i) begin
      if (rst_i)         cfg_q <= pins_cfg;
      else if (hw_i)     cfg_q <= pins_cfg;
      else if (commit_i) cfg_q <= wdata_i;
   end

   assign ctl_o  = cfg_q[CFG_W-1 -: CTL_W];
   assign rate_o = cfg_q[RATE_W-1:0];

   AST_HW_TRACK: assert property (@(posedge clk_i) disable iff (rst_i)
      hw_i |=> (cfg_q == $past(pins_cfg))) else $error("hw track"); // R7
   AST_SW_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (!hw_i && !commit_i) |=> $stable(cfg_q)) else $error("sw hold"); // R7

endmodule

// File: rtl/sp_rd_path.sv
module sp_rd_path
   import cfgp_pkg::*;
#(
   parameter int RES_W  = 24,
   parameter int STAT_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [RES_W-1:0]  result_i,
   input  logic              result_vld_i,
   input  logic [STAT_W-1:0] status_i,
   input  logic              load_i,
   input  logic              sel_res_i,
   input  logic              shift_i,
   input  logic              done_i,
   output logic              dout_o,
   output logic              drdy_o
);

   localparam int SH_W = max_u(RES_W, STAT_W);

   if (SH_W < 2) begin : g_bad_sh
      $error("sp_rd_path: read width must be at least 2");
   end

   logic [RES_W-1:0] hold_q;
   logic             drdy_q;
   logic             fresh_q;
   logic [SH_W-1:0]  sh_q;
   logic [SH_W-1:0]  res_al;
   logic [SH_W-1:0]  stat_al;

   if (RES_W == SH_W) begin : g_res_full
      assign res_al = hold_q;
   end else begin : g_res_pad
      assign res_al = {hold_q, {(SH_W-RES_W){1'b0}}};
   end

   if (STAT_W == SH_W) begin : g_stat_full
      assign stat_al = status_i;
   end else begin : g_stat_pad
      assign stat_al = {status_i, {(SH_W-STAT_W){1'b0}}};
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hold_q  <= '0;
         drdy_q  <= 1'b0;
         fresh_q <= 1'b0;
         sh_q    <= '0;
      end else begin
         if (result_vld_i) hold_q <= result_i;

         if (result_vld_i)                drdy_q <= 1'b1;
         else if (done_i && !fresh_q)     drdy_q <= 1'b0;

         if (load_i)            fresh_q <= result_vld_i;
         else if (result_vld_i) fresh_q <= 1'b1;

         if (load_i)       sh_q <= sel_res_i ? res_al : stat_al;
         else if (shift_i) sh_q <= {sh_q[SH_W-2:0], 1'b0};
      end
   end

   assign dout_o = sh_q[SH_W-1];
   assign drdy_o = drdy_q;

   AST_DRDY_SET: assert property (@(posedge clk_i) disable iff (rst_i)
      result_vld_i |=> drdy_o) else $error("drdy set"); // R9
   AST_FRESH_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_i && fresh_q) |=> drdy_o) else $error("fresh keep"); // R10
   AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !result_vld_i |=> $stable(hold_q)) else $error("hold stable"); // R10
   AST_LOAD_MSB: assert property (@(posedge clk_i) disable iff (rst_i)
      (load_i && sel_res_i) |=> (dout_o == $past(hold_q[RES_W-1]))) else $error("load msb"); // R3

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfgp_pkg::*;
#(
   parameter int RES_W       = 24,
   parameter int STAT_W      = 8,
   parameter int CTL_W       = 5,
   parameter int RATE_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              csn_i,
   input  logic              rdwr_i,
   input  logic              rsel_i,
   input  logic              sclk_i,
   input  logic              din_i,
   output logic              dout_o,
   output logic              dout_oe_o,
   output logic              drdy_o,
   input  logic              hwmode_i,
   input  logic [CTL_W-1:0]  ctl_pins_i,
   input  logic [RATE_W-1:0] rate_pins_i,
   input  logic [RES_W-1:0]  result_i,
   input  logic              result_vld_i,
   input  logic [STAT_W-1:0] status_i,
   output logic [CTL_W-1:0]  ctl_o,
   output logic [RATE_W-1:0] rate_o
);

   localparam int CFG_W = CTL_W + RATE_W;
   localparam int MAXN  = max_u(max_u(RES_W, STAT_W), CFG_W);
   localparam int CNT_W = $clog2(MAXN + 2);
   localparam logic [CNT_W-1:0] CNT_CFG = CNT_W'(CFG_W);
   localparam logic [CNT_W-1:0] CNT_RES = CNT_W'(RES_W);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAXN + 1);

   localparam int I_RSEL = 0;
   localparam int I_RDWR = 1;
   localparam int I_DIN  = 2;
   localparam int I_SCLK = 3;
   localparam int I_CSN  = 4;

   if (RES_W < 1 || STAT_W < 1 || CTL_W < 1 || RATE_W < 1) begin : g_bad_w
      $error("cfg_serial_port: all widths must be positive");
   end

   logic [4:0] raw, lvl, rise, fall;
   assign raw = {csn_i, sclk_i, din_i, rdwr_i, rsel_i};

   sp_sync_edge #(.N(5), .STAGES(SYNC_STAGES), .IDLE(5'b11000)) u_sync (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .async_i (raw),
      .lvl_o   (lvl),
      .rise_o  (rise),
      .fall_o  (fall)
   );

   logic [11:0] unused_sync;
   assign unused_sync = {lvl[I_SCLK], rise[I_DIN], rise[I_RDWR], rise[I_RSEL],
                         fall[I_DIN], fall[I_RDWR], fall[I_RSEL],
                         rise[I_SCLK] & fall[I_SCLK], 4'd0};

   frame_e           frame_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CFG_W-1:0] wsh_q;
   logic             fr_start, fr_end, sclk_fall, sclk_rise;
   logic             commit, rd_done, rd_load, rd_shift;

   assign fr_start  = fall[I_CSN];
   assign fr_end    = rise[I_CSN];
   assign sclk_fall = fall[I_SCLK] & ~lvl[I_CSN];
   assign sclk_rise = rise[I_SCLK] & ~lvl[I_CSN];

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         frame_q <= FR_IDLE;
         cnt_q   <= '0;
         wsh_q   <= '0;
      end else if (fr_start) begin
         frame_q <= lvl[I_RDWR] ? (lvl[I_RSEL] ? FR_RD_RES : FR_RD_STAT) : FR_WRITE;
         cnt_q   <= '0;
      end else if (fr_end) begin
         frame_q <= FR_IDLE;
      end else if (sclk_fall && frame_q != FR_IDLE) begin
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         if (frame_q == FR_WRITE) wsh_q <= {wsh_q[CFG_W-2:0], lvl[I_DIN]};
      end
   end

   assign commit   = fr_end && frame_q == FR_WRITE && cnt_q == CNT_CFG;
   assign rd_done  = fr_end && frame_q == FR_RD_RES && cnt_q >= CNT_RES;
   assign rd_load  = fr_start && lvl[I_RDWR];
   assign rd_shift = sclk_rise && (frame_q == FR_RD_RES || frame_q == FR_RD_STAT);

   sp_cfg_reg #(.CTL_W(CTL_W), .RATE_W(RATE_W)) u_cfg (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .hw_i        (hwmode_i),
      .ctl_pins_i  (ctl_pins_i),
      .rate_pins_i (rate_pins_i),
      .commit_i    (commit),
      .wdata_i     (wsh_q),
      .ctl_o       (ctl_o),
      .rate_o      (rate_o)
   );

   sp_rd_path #(.RES_W(RES_W), .STAT_W(STAT_W)) u_rd (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .result_i     (result_i),
      .result_vld_i (result_vld_i),
      .status_i     (status_i),
      .load_i       (rd_load),
      .sel_res_i    (lvl[I_RSEL]),
      .shift_i      (rd_shift),
      .done_i       (rd_done),
      .dout_o       (dout_o),
      .drdy_o       (drdy_o)
   );

   assign dout_oe_o = ~csn_i & rdwr_i;

   AST_WR_COMMIT: assert property (@(posedge clk_i) disable iff (rst_i)
      (commit && !hwmode_i) |=> ({ctl_o, rate_o} == $past(wsh_q))) else $error("commit"); // R5
   AST_SHORT_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
      (fr_end && frame_q == FR_WRITE && cnt_q != CNT_CFG && !hwmode_i)
      |=> $stable({ctl_o, rate_o})) else $error("short write"); // R6
   AST_IDLE_NO_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
      (frame_q == FR_IDLE && !fr_start) |=> $stable(cnt_q)) else $error("idle count"); // R1

endmodule

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;

   logic        clk = 1'b0;
   logic        rst_i = 1'b1;
   logic        csn_i = 1'b1;
   logic        rdwr_i = 1'b0;
   logic        rsel_i = 1'b0;
   logic        sclk_i = 1'b1;
   logic        din_i = 1'b0;
   logic        hwmode_i = 1'b0;
   logic [4:0]  ctl_pins_i = 5'b10110;
   logic [2:0]  rate_pins_i = 3'b101;
   logic [23:0] result_i = '0;
   logic        result_vld_i = 1'b0;
   logic [7:0]  status_i = '0;
   logic        dout_o, dout_oe_o, drdy_o;
   logic [4:0]  ctl_o;
   logic [2:0]  rate_o;

   int    checks = 0;
   int    errors = 0;
   logic  mon_rd = 1'b0;
   string mon_tag = "R3";
   logic  exp_q [$];

   always #10 clk = ~clk;

   cfg_serial_port u0 (
      .clk_i(clk), .rst_i(rst_i), .csn_i(csn_i), .rdwr_i(rdwr_i), .rsel_i(rsel_i),
      .sclk_i(sclk_i), .din_i(din_i), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
      .drdy_o(drdy_o), .hwmode_i(hwmode_i), .ctl_pins_i(ctl_pins_i),
      .rate_pins_i(rate_pins_i), .result_i(result_i), .result_vld_i(result_vld_i),
      .status_i(status_i), .ctl_o(ctl_o), .rate_o(rate_o)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic push_top(input logic [31:0] val, input int w, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(val[w-1-i]);
   endtask

   task automatic push_result(input logic [23:0] val);
      result_i = val; result_vld_i = 1'b1; tick(1);
      result_vld_i = 1'b0; tick(1);
   endtask

   task automatic frame(input logic rw, input logic sel, input int nbits,
                        input logic [31:0] wdata, input int inj_at, input logic [23:0] inj_val);
      rdwr_i = rw; rsel_i = sel; tick(2);
      csn_i = 1'b0; tick(6);
      mon_rd = rw;
      for (int i = 0; i < nbits; i++) begin
         if (i == inj_at) begin
            result_i = inj_val; result_vld_i = 1'b1; tick(1); result_vld_i = 1'b0;
         end
         din_i = rw ? 1'b0 : wdata[nbits-1-i];
         sclk_i = 1'b0; tick(4);
         sclk_i = 1'b1; tick(4);
      end
      mon_rd = 1'b0;
      tick(2); csn_i = 1'b1; tick(6);
   endtask

   // scoreboard monitor: one expected bit per falling serial-clock edge
   always @(negedge sclk_i) begin
      if (mon_rd) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s act=%0b exp=<none>", mon_tag, dout_o);
         end else begin
            automatic logic e = exp_q.pop_front();
            if (dout_o !== e) begin
               errors++;
               $display("FAIL %s act=%0b exp=%0b", mon_tag, dout_o, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=done");
      report();
      $finish;
   end

   initial begin
      tick(5); rst_i = 1'b0; tick(2);
      // R8 reset state
      chk("R8 ctl", ctl_o, 5'h16);
      chk("R8 rate", rate_o, 3'd5);
      chk("R8 drdy", drdy_o, 0);
      chk("R1 oe idle", dout_oe_o, 0);
      // R7 pins ignored in software mode
      ctl_pins_i = 5'b00001; rate_pins_i = 3'b010; tick(3);
      chk("R7 sw pins ignored", {ctl_o, rate_o}, {5'h16, 3'd5});
      // R2 output enable
      csn_i = 1'b0; rdwr_i = 1'b1; tick(1);
      chk("R2 oe read", dout_oe_o, 1);
      rdwr_i = 1'b0; tick(1);
      chk("R2 oe write", dout_oe_o, 0);
      csn_i = 1'b1; tick(6);
      // R5 full write
      frame(1'b0, 1'b0, 8, 32'hA5, -1, '0);
      chk("R5 ctl", ctl_o, 5'h14);
      chk("R5 rate", rate_o, 3'd5);
      // R6 short and long writes
      frame(1'b0, 1'b0, 7, 32'h00, -1, '0);
      chk("R6 short", {ctl_o, rate_o}, 8'hA5);
      frame(1'b0, 1'b0, 9, 32'h0FF, -1, '0);
      chk("R6 long", {ctl_o, rate_o}, 8'hA5);
      // R1 activity with chip select high
      rdwr_i = 1'b0;
      for (int i = 0; i < 8; i++) begin
         din_i = 1'b0; sclk_i = 1'b0; tick(4); sclk_i = 1'b1; tick(4);
      end
      tick(4);
      chk("R1 cfg", {ctl_o, rate_o}, 8'hA5);
      chk("R1 oe", dout_oe_o, 0);
      chk("R1 drdy", drdy_o, 0);
      // R9 / R3 result read
      push_result(24'h123456); tick(1);
      chk("R9 drdy set", drdy_o, 1);
      mon_tag = "R3"; push_top(32'h123456, 24, 24);
      frame(1'b1, 1'b1, 24, '0, -1, '0);
      chk("R3 all bits", exp_q.size(), 0);
      chk("R9 drdy clr", drdy_o, 0);
      // R4 status read, R9 flag kept
      push_result(24'hABCDEF); tick(1);
      status_i = 8'h3C;
      mon_tag = "R4"; push_top(32'h3C, 8, 8);
      frame(1'b1, 1'b0, 8, '0, -1, '0);
      chk("R4 all bits", exp_q.size(), 0);
      chk("R9 status keeps", drdy_o, 1);
      // R9 short result read keeps flag
      mon_tag = "R9"; push_top(32'hABCDEF, 24, 10);
      frame(1'b1, 1'b1, 10, '0, -1, '0);
      chk("R9 short bits", exp_q.size(), 0);
      chk("R9 short keeps", drdy_o, 1);
      // R10 result arrives mid-read
      mon_tag = "R10"; push_top(32'hABCDEF, 24, 24);
      frame(1'b1, 1'b1, 24, '0, 12, 24'h5A5A5A);
      chk("R10 bits", exp_q.size(), 0);
      chk("R10 drdy kept", drdy_o, 1);
      push_top(32'h5A5A5A, 24, 24);
      frame(1'b1, 1'b1, 24, '0, -1, '0);
      chk("R10 new bits", exp_q.size(), 0);
      chk("R10 drdy clr", drdy_o, 0);
      // R7 hardware mode
      hwmode_i = 1'b1; ctl_pins_i = 5'b01011; rate_pins_i = 3'b110; tick(2);
      chk("R7 hw track", {ctl_o, rate_o}, {5'h0B, 3'd6});
      frame(1'b0, 1'b0, 8, 32'hFF, -1, '0);
      chk("R7 hw write ignored", {ctl_o, rate_o}, {5'h0B, 3'd6});
      ctl_pins_i = 5'b11100; rate_pins_i = 3'b001; tick(2);
      chk("R7 hw follow", {ctl_o, rate_o}, {5'h1C, 3'd1});
      hwmode_i = 1'b0; tick(1);
      ctl_pins_i = 5'b00000; rate_pins_i = 3'b000; tick(3);
      chk("R7 sw hold", {ctl_o, rate_o}, {5'h1C, 3'd1});
      frame(1'b0, 1'b0, 8, 32'h3A, -1, '0);
      chk("R5 second write", {ctl_o, rate_o}, {5'h07, 3'd2});
      // R8 reset reload
      push_result(24'h000001);
      ctl_pins_i = 5'b00110; rate_pins_i = 3'b011;
      rst_i = 1'b1; tick(3); rst_i = 1'b0; tick(2);
      chk("R8 reload", {ctl_o, rate_o}, {5'h06, 3'd3});
      chk("R8 drdy clr", drdy_o, 0);
      report();
      $finish;
   end

endmodule